// File: doc/BRIEF.md
# Four-Channel Synthesizer Configuration Register Bank

This block holds the settings of a four-output frequency synthesizer and of the shared PLL that feeds it. It sits on a simple word-addressed read/write bus. For each output channel it stores a parameter word with four fields: a 15-bit fine phase step, a 5-bit coarse divider, a 4-bit power-of-two divider and a divide-by-three bypass bit. It also stores per-channel reset and standby bits, a shared PLL power-down bit and a 3-bit PLL multiplier. It reports the PLL lock input as a read-only bit.

Channel parameters are double-buffered. Bus writes only change a staging copy. The active copy that drives the synthesizer changes only when software raises that channel's program-enable bit from 0 to 1. All fields of a channel then switch together in one clock cycle, so a running output can be retuned without glitches. Software programs the staging word, pulses the enable bit high, and later returns it to 0.

Top module: `synth_cfg_bank`

## Requirements
- R1: After reset every staging and active parameter word is zero, every channel reset bit is 1, every standby bit is 1, PLL power-down is 1, the multiplier is 0 and every program-enable bit is 0.
- R2: Channel i's staging word sits at byte offset 0x10 + 4*i. Its fine step is bits 14:0, coarse divider bits 19:15, power-of-two divider bits 23:20 and bypass bit 24. Bits above 24 read as 0. A staging write leaves the active outputs unchanged.
- R3: A write to the program-enable register (offset 0x08, channel i at bit i) that takes bit i from 0 to 1 copies staging word i into active word i. The new value is visible on `chanParam` right after that clock edge, and no other channel changes.
- R4: A program-enable write that leaves bit i at 1, or that writes bit i as 0, does not change active word i.
- R5: The control word at offset 0x00 holds the channel resets in bits 3:0, standby in bits 11:8 and PLL power-down in bit 12. These drive `chanRst` and `pllPd`.
- R6: A channel is reported running (`chanRun` bit i = 1) exactly when its standby bit is 0.
- R7: Bit 24 of the control word reads the current `lockIn` level. Writing that bit has no effect.
- R8: The PLL multiplier is bits 18:16 of offset 0x04 and drives `pllMult`. The other bits of that word read as 0.
- R9: Offsets outside the map, and offsets whose two low bits are not zero, read as 0, and writes to them change nothing.
- R10: `chanUnprog` bit i is 1 while active word i has its fine, coarse and power-of-two fields all zero, whatever the bypass bit holds.
- R11: `rdData` takes the addressed value on the clock edge where `rdEn` is sampled high, and holds its value while `rdEn` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for `addr`/`wrData` |
| rdEn | input | 1 | Read strobe for `addr` |
| addr | input | 8 | Byte address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data |
| lockIn | input | 1 | PLL lock level, visible as a read-only bit |
| chanParam | output | 100 | Active parameter words, channel i at bits 25*i+24:25*i |
| chanRst | output | 4 | Per-channel reset |
| chanRun | output | 4 | Per-channel running indication |
| chanUnprog | output | 4 | Per-channel unprogrammed flag |
| pllPd | output | 1 | PLL power-down |
| pllMult | output | 3 | PLL multiplier field |

## Verification
The assertions assume the bus raises at most one of `wrEn` and `rdEn` in a cycle, and that both stay low while reset is held. They also assume `lockIn` changes only between cycles, so the value sampled on a read edge is the one reported. The stimulus drives every input on the falling edge, issues one access at a time with idle cycles between, and keeps both strobes low through reset. In this way, the one-cycle read and commit relations are always checked against a single, unambiguous bus operation.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;

  // Register byte offsets
  localparam int unsigned OFS_CTL  = 32'h00;
  localparam int unsigned OFS_MULT = 32'h04;
  localparam int unsigned OFS_PGM  = 32'h08;
  localparam int unsigned OFS_CH0  = 32'h10;

  // Control word field positions
  localparam int unsigned STBY_LSB = 8;
  localparam int unsigned PD_BIT   = 12;
  localparam int unsigned LOCK_BIT = 24;
  localparam int unsigned MULT_LSB = 16;

  typedef struct packed {
    logic wrCtl;
    logic wrMult;
    logic wrPgm;
    logic wrChan;
    logic rdStb;
  } cfgStrobe_t;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTL,
    SEL_MULT,
    SEL_PGM,
    SEL_CHAN
  } rdSel_t;

endpackage

// File: rtl/synth_cfg_decode.sv
module synth_cfg_decode
  import synth_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned NUM_CH   = 4,
  parameter int unsigned CH_SEL_W = 2
) (
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic [ADDR_W-1:0]   addr,
  output cfgStrobe_t          stb,
  output rdSel_t              rdSel,
  output logic [CH_SEL_W-1:0] chanSel
);

  localparam int unsigned CH_END = OFS_CH0 + 4 * NUM_CH;

  logic              aligned;
  logic              hitCtl, hitMult, hitPgm, hitChan;
  logic [ADDR_W-1:0] chOff;
  logic              unusedOff;

  assign aligned = (addr[1:0] == 2'b00);
  assign hitCtl  = aligned && (addr == ADDR_W'(OFS_CTL));
  assign hitMult = aligned && (addr == ADDR_W'(OFS_MULT));
  assign hitPgm  = aligned && (addr == ADDR_W'(OFS_PGM));
  assign hitChan = aligned && (32'(addr) >= OFS_CH0) && (32'(addr) < CH_END);

  assign chOff     = addr - ADDR_W'(OFS_CH0);
  assign chanSel   = chOff[2 +: CH_SEL_W];
  assign unusedOff = ^{chOff[1:0], chOff[ADDR_W-1:2+CH_SEL_W]};

  always_comb begin
    stb        = '0;
    stb.wrCtl  = wrEn && hitCtl;
    stb.wrMult = wrEn && hitMult;
    stb.wrPgm  = wrEn && hitPgm;
    stb.wrChan = wrEn && hitChan;
    stb.rdStb  = rdEn;
  end

  always_comb begin
    if (hitCtl)       rdSel = SEL_CTL;
    else if (hitMult) rdSel = SEL_MULT;
    else if (hitPgm)  rdSel = SEL_PGM;
    else if (hitChan) rdSel = SEL_CHAN;
    else              rdSel = SEL_NONE;
  end

endmodule

// File: rtl/synth_cfg_regs.sv
module synth_cfg_regs
  import synth_cfg_pkg::*;
#(
  parameter int unsigned NUM_CH   = 4,
  parameter int unsigned FINE_W   = 15,
  parameter int unsigned COARSE_W = 5,
  parameter int unsigned POW_W    = 4,
  parameter int unsigned MULT_W   = 3,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CH_SEL_W = 2,
  localparam int unsigned PARAM_W = FINE_W + COARSE_W + POW_W + 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  cfgStrobe_t                 stb,
  input  rdSel_t                     rdSel,
  input  logic [CH_SEL_W-1:0]        chanSel,
  input  logic [DATA_W-1:0]          wrData,
  input  logic                       lockIn,
  output logic [DATA_W-1:0]          rdData,
  output logic [NUM_CH*PARAM_W-1:0]  chanParam,
  output logic [NUM_CH-1:0]          chanRst,
  output logic [NUM_CH-1:0]          chanRun,
  output logic [NUM_CH-1:0]          chanUnprog,
  output logic                       pllPd,
  output logic [MULT_W-1:0]          pllMult
);

  localparam int unsigned TUNE_W = PARAM_W - 1;

  logic [PARAM_W-1:0] staging [NUM_CH];
  logic [PARAM_W-1:0] active  [NUM_CH];
  logic [NUM_CH-1:0]  ctlRst, ctlStby, pgmReg, commit;
  logic               ctlPd;
  logic [MULT_W-1:0]  multReg;
  logic [DATA_W-1:0]  rdNext;
  logic               unusedWr;

  assign unusedWr = ^wrData;

  // A commit is a 0 -> 1 transition of a program-enable bit
  assign commit = stb.wrPgm ? (wrData[NUM_CH-1:0] & ~pgmReg) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlRst  <= '1;
      ctlStby <= '1;
      ctlPd   <= 1'b1;
      multReg <= '0;
      pgmReg  <= '0;
      for (int i = 0; i < NUM_CH; i++) begin
        staging[i] <= '0;
        active[i]  <= '0;
      end
    end else begin
      if (stb.wrCtl) begin
        ctlRst  <= wrData[NUM_CH-1:0];
        ctlStby <= wrData[STBY_LSB +: NUM_CH];
        ctlPd   <= wrData[PD_BIT];
      end
      if (stb.wrMult) multReg <= wrData[MULT_LSB +: MULT_W];
      if (stb.wrPgm)  pgmReg  <= wrData[NUM_CH-1:0];
      for (int i = 0; i < NUM_CH; i++) begin
        if (stb.wrChan && (chanSel == CH_SEL_W'(i))) staging[i] <= wrData[PARAM_W-1:0];
        if (commit[i]) active[i] <= staging[i];
      end
    end
  end

  always_comb begin
    rdNext = '0;
    unique case (rdSel)
      SEL_CTL: begin
        rdNext[NUM_CH-1:0]          = ctlRst;
        rdNext[STBY_LSB +: NUM_CH]  = ctlStby;
        rdNext[PD_BIT]              = ctlPd;
        rdNext[LOCK_BIT]            = lockIn;
      end
      SEL_MULT: rdNext[MULT_LSB +: MULT_W] = multReg;
      SEL_PGM:  rdNext[NUM_CH-1:0]         = pgmReg;
      SEL_CHAN: rdNext[PARAM_W-1:0]        = staging[chanSel];
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)          rdData <= '0;
    else if (stb.rdStb) rdData <= rdNext;
  end

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : gOut
      assign chanParam[g*PARAM_W +: PARAM_W] = active[g];
      assign chanUnprog[g] = (active[g][TUNE_W-1:0] == '0);
    end
  endgenerate

  assign chanRst = ctlRst;
  assign chanRun = ~ctlStby;
  assign pllPd   = ctlPd;
  assign pllMult = multReg;

endmodule

// File: rtl/synth_cfg_bank.sv
module synth_cfg_bank
  import synth_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_CH   = 4,
  parameter int unsigned FINE_W   = 15,
  parameter int unsigned COARSE_W = 5,
  parameter int unsigned POW_W    = 4,
  parameter int unsigned MULT_W   = 3,
  localparam int unsigned PARAM_W  = FINE_W + COARSE_W + POW_W + 1,
  localparam int unsigned CH_SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wrEn,
  input  logic                      rdEn,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wrData,
  output logic [DATA_W-1:0]         rdData,
  input  logic                      lockIn,
  output logic [NUM_CH*PARAM_W-1:0] chanParam,
  output logic [NUM_CH-1:0]         chanRst,
  output logic [NUM_CH-1:0]         chanRun,
  output logic [NUM_CH-1:0]         chanUnprog,
  output logic                      pllPd,
  output logic [MULT_W-1:0]         pllMult
);

  cfgStrobe_t          stb;
  rdSel_t              rdSel;
  logic [CH_SEL_W-1:0] chanSel;

  synth_cfg_decode #(
    .ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .CH_SEL_W(CH_SEL_W)
  ) u_decode (
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .stb(stb), .rdSel(rdSel), .chanSel(chanSel)
  );

  synth_cfg_regs #(
    .NUM_CH(NUM_CH), .FINE_W(FINE_W), .COARSE_W(COARSE_W), .POW_W(POW_W),
    .MULT_W(MULT_W), .DATA_W(DATA_W), .CH_SEL_W(CH_SEL_W)
  ) u_regs (
    .clk(clk), .rstN(rstN), .stb(stb), .rdSel(rdSel), .chanSel(chanSel),
    .wrData(wrData), .lockIn(lockIn), .rdData(rdData),
    .chanParam(chanParam), .chanRst(chanRst), .chanRun(chanRun),
    .chanUnprog(chanUnprog), .pllPd(pllPd), .pllMult(pllMult)
  );

endmodule

// File: rtl/synth_cfg_bank_chk.sv
module synth_cfg_bank_chk
  import synth_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_CH  = 4,
  parameter int unsigned PARAM_W = 25,
  parameter int unsigned MULT_W  = 3
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      wrEn,
  input logic                      rdEn,
  input logic [ADDR_W-1:0]         addr,
  input logic [DATA_W-1:0]         wrData,
  input logic [DATA_W-1:0]         rdData,
  input logic                      lockIn,
  input logic [NUM_CH*PARAM_W-1:0] chanParam,
  input logic                      pllPd,
  input logic [MULT_W-1:0]         pllMult
);

  logic wrPgmBus;
  assign wrPgmBus = wrEn && (addr == ADDR_W'(OFS_PGM));

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : gHold
      // R4
      param_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
        !wrPgmBus |=> $stable(chanParam[g*PARAM_W +: PARAM_W]));
    end
  endgenerate

  // R5
  pd_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(OFS_CTL)) |=> (pllPd == $past(wrData[PD_BIT])));

  // R8
  mult_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(OFS_MULT)) |=> (pllMult == $past(wrData[MULT_LSB +: MULT_W])));

  // R7
  lock_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == ADDR_W'(OFS_CTL)) |=> (rdData[LOCK_BIT] == $past(lockIn)));

  // R9
  misalign_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr[1:0] != 2'b00) |=> (rdData == '0));

  // R11
  read_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));

endmodule

bind synth_cfg_bank synth_cfg_bank_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CH(NUM_CH),
  .PARAM_W(PARAM_W), .MULT_W(MULT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
  .wrData(wrData), .rdData(rdData), .lockIn(lockIn),
  .chanParam(chanParam), .pllPd(pllPd), .pllMult(pllMult)
);

// File: tb/synth_cfg_bank_bench.sv
`timescale 1ns/1ps
module synth_cfg_bank_bench;

  localparam int PW = 25;

  typedef struct packed {
    logic        isWr;
    logic [7:0]  a;
    logic [31:0] d;
  } vec_t;

  // Walked in order; reads compare against d. lockIn is 1 during the walk.
  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 8'h10, 32'h01AB_CDEF},  // R2 stage ch0
    '{1'b0, 8'h10, 32'h01AB_CDEF},  // R2
    '{1'b1, 8'h14, 32'hFFFF_FFFF},  // R2 stage ch1
    '{1'b0, 8'h14, 32'h01FF_FFFF},  // R2 upper bits zero
    '{1'b1, 8'h00, 32'hFFFF_FFFF},  // R5
    '{1'b0, 8'h00, 32'h0100_1F0F},  // R5 R7
    '{1'b1, 8'h00, 32'h0000_0000},  // R5
    '{1'b0, 8'h00, 32'h0100_0000},  // R7
    '{1'b1, 8'h04, 32'hFFFF_FFFF},  // R8
    '{1'b0, 8'h04, 32'h0007_0000},  // R8
    '{1'b1, 8'h08, 32'hFFFF_FFF0},  // R4 no channel bit set
    '{1'b0, 8'h08, 32'h0000_0000},
    '{1'b1, 8'h20, 32'hFFFF_FFFF},  // R9
    '{1'b0, 8'h20, 32'h0000_0000},  // R9
    '{1'b0, 8'h0C, 32'h0000_0000},  // R9
    '{1'b0, 8'h11, 32'h0000_0000},  // R9
    '{1'b1, 8'h04, 32'h0000_0000},  // R8
    '{1'b0, 8'h04, 32'h0000_0000},  // R8
    '{1'b1, 8'h13, 32'hFFFF_FFFF},  // R9 misaligned write
    '{1'b0, 8'h10, 32'h01AB_CDEF}   // R9 ch0 untouched
  };

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wrEn = 1'b0, rdEn = 1'b0, lockIn = 1'b0;
  logic [7:0]   addr = '0;
  logic [31:0]  wrData = '0;
  logic [31:0]  rdData;
  logic [4*PW-1:0] chanParam;
  logic [3:0]   chanRst, chanRun, chanUnprog;
  logic         pllPd;
  logic [2:0]   pllMult;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  synth_cfg_bank u_synth_cfg_bank (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .lockIn(lockIn),
    .chanParam(chanParam), .chanRst(chanRst), .chanRun(chanRun),
    .chanUnprog(chanUnprog), .pllPd(pllPd), .pllMult(pllMult)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  function automatic logic [31:0] chP(input int i);
    return 32'(chanParam[i*PW +: PW]);
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 ch0", chP(0), 0);
    chk("R1 ch3", chP(3), 0);
    chk("R1 rst", 32'(chanRst), 32'hF);
    chk("R1 run", 32'(chanRun), 32'h0);
    chk("R1 pd", 32'(pllPd), 32'h1);
    chk("R1 mult", 32'(pllMult), 32'h0);
    chk("R10 reset unprog", 32'(chanUnprog), 32'hF);
    busRd(8'h00, rv); chk("R1 ctl read", rv, 32'h0000_1F0F);
    busRd(8'h08, rv); chk("R1 pgm read", rv, 32'h0);

    // Vector walk
    lockIn = 1'b1;
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].isWr) busWr(VEC[i].a, VEC[i].d);
      else begin
        busRd(VEC[i].a, rv);
        chk($sformatf("R2/R5/R7/R8/R9 vec%0d", i), rv, VEC[i].d);
      end
    end

    // R2 staging has not reached active
    chk("R2 ch0 not active", chP(0), 0);
    chk("R2 ch1 not active", chP(1), 0);

    // R3 commit ch0
    busWr(8'h08, 32'h1);
    chk("R3 ch0 commit", chP(0), 32'h01AB_CDEF);
    chk("R3 ch1 untouched", chP(1), 0);
    chk("R10 unprog after commit", 32'(chanUnprog), 32'hE);

    // R4 held-high and low writes do not commit
    busWr(8'h10, 32'h0000_0123);
    busWr(8'h08, 32'h1);
    chk("R4 held high", chP(0), 32'h01AB_CDEF);
    busWr(8'h08, 32'h0);
    chk("R4 write zero", chP(0), 32'h01AB_CDEF);
    busWr(8'h08, 32'h1);
    chk("R3 second commit", chP(0), 32'h0000_0123);

    // R3 only ch2 commits; R10 bypass-only word is unprogrammed
    busWr(8'h18, 32'h0100_0000);
    busWr(8'h08, 32'h4);
    chk("R3 ch2 commit", chP(2), 32'h0100_0000);
    chk("R3 ch0 kept", chP(0), 32'h0000_0123);
    chk("R3 ch1 kept", chP(1), 0);
    chk("R10 bypass only", 32'(chanUnprog), 32'hE);

    // R5 R6 control word
    busWr(8'h00, 32'h0000_0A05);
    chk("R5 rst", 32'(chanRst), 32'h5);
    chk("R6 run", 32'(chanRun), 32'h5);
    chk("R5 pd low", 32'(pllPd), 32'h0);
    busWr(8'h00, 32'h0000_1000);
    chk("R5 pd high", 32'(pllPd), 32'h1);
    chk("R6 all run", 32'(chanRun), 32'hF);

    // R8 multiplier
    busWr(8'h04, 32'h0005_0000);
    chk("R8 mult out", 32'(pllMult), 32'h5);

    // R7 lock bit follows input, write ignored
    lockIn = 1'b0;
    busWr(8'h00, 32'h0100_0000);
    busRd(8'h00, rv); chk("R7 lock low", rv, 32'h0000_0000);
    lockIn = 1'b1;
    busRd(8'h00, rv); chk("R7 lock high", rv, 32'h0100_0000);

    // R11 read data holds
    busRd(8'h10, rv); chk("R11 read", rv, 32'h0000_0123);
    busWr(8'h10, 32'h0000_0777);
    repeat (3) @(negedge clk);
    chk("R11 hold", rdData, 32'h0000_0123);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule